// File: doc/BRIEF.md
# Serial Frame Transmitter with Embedded Flow and Status Codes

This block turns a stream of 32-bit words from a first-word-fall-through FIFO into the framed character stream of a serial front-panel data link. Every cycle it presents one 32-bit word to the downstream 8b/10b encoder, tagged either as a data character or as an ordered set. Between frames it sends fill ordered sets. A frame opens with a start ordered set whose code carries three side-band flag bits. The data words follow, then an optional CRC word and a GO or STOP flow-control code. The frame closes with a status end code carrying the overrun and not-ready bits, followed by an end code that tells normal frames apart from SYNC frames.

The frame is closed on one of three conditions: the FIFO runs dry, the word limit is reached, or the source asks for a SYNC marker. A SYNC marker is a frame of exactly one word. It is announced by a dedicated mark ordered set sent in place of the fill word directly before its start code. Outputs are registered, so a decision taken in one cycle appears on `tx_word` after the next rising edge. The FIFO pop is combinational and is taken on that same edge.

Top module: `sfx_frame_tx`

## Requirements
- R1: While `rst_n` is low, the output is the fill code 0x00000001 with `tx_is_os`=1, and `fifo_pop` stays 0 even when the FIFO holds words.
- R2: Every start code is directly preceded by one gap word. The gap word is fill (0x01) for a normal frame and mark (0x02) for a SYNC frame. Fill is sent whenever no frame is in progress.
- R3: A frame is sent as a contiguous run of words in this order: start code, data words, CRC word (when enabled), flow code, status end code, frame end code.
- R4: The start code is 0x10 | {f2,f1,f0}, where `sof_flags[2:0]` occupies bits 2..0 and is sampled in the start cycle of each frame.
- R5: Each frame carries between 1 and MAX_WORDS (default 512) data words. When more words are waiting, the data is split across several frames.
- R6: A normal frame closes when the FIFO runs empty. A burst of N ≤ MAX_WORDS words loaded at once forms a single frame of N words.
- R7: With `sync_req` high at the gap decision, the next frame is a SYNC frame. It is marked by 0x02, carries exactly one word and ends with code 0x41. `sync_taken` pulses in the cycle that word is popped. A normal frame ends with 0x40.
- R8: A `sync_req` that arrives during a normal frame closes that frame after its current word. The frame always keeps at least one word, even if the request comes at its start.
- R9: When `crc_on` is 1 at the start cycle, a CRC word (`tx_is_os`=0) follows the data. The CRC is the CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF, processed MSB first per word, with no reflection and no final XOR. When `crc_on` is 0, the CRC slot is left out.
- R10: The flow code is 0x21 (STOP) when `backoff` is high in its slot, and 0x20 (GO) otherwise.
- R11: The status end code is 0x30 | {overrun, not_ready}, with `overrun` at bit 1 and `not_ready` at bit 0.
- R12: Data words leave unchanged, in FIFO order, with `tx_is_os`=0. `fifo_pop` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 32 | Head word of the FIFO (first-word fall-through) |
| fifo_pop | output | 1 | Remove the head word at this edge |
| sync_req | input | 1 | Request a SYNC marker frame (level, held until taken) |
| sync_taken | output | 1 | The SYNC frame's word is being popped |
| crc_on | input | 1 | Append a CRC word to frames that start now |
| backoff | input | 1 | Far receiver asks this end to stop |
| sof_flags | input | 3 | Side-band flags carried in the start code |
| overrun | input | 1 | Local transmit FIFO overflow flag for the status code |
| not_ready | input | 1 | Not-ready flag for the status code |
| tx_word | output | 32 | Outgoing word |
| tx_is_os | output | 1 | 1 when `tx_word` is an ordered set code |

## Verification
The bench loads a burst of 600 words to test the length limit. A frame counter that ignored the limit would send one 600-word frame, and an off-by-one would give 511/89 or 513/87 instead of 512/88. SYNC requests are raised in three ways: with the burst, partway through a frame, and in the cycle just before the start code. A design that skipped the one-word minimum would send an empty frame. One that ignored the mid-frame request would hold the marker until the FIFO ran dry. CRC words are compared against a bench model, and each frame's data is matched against the FIFO contents. This catches a CRC register that misses its reseed at the start code, and a pop that drops or repeats a word. Random bursts vary the flags, CRC setting, flow state and status bits between frames. Miswired code bits would therefore show up as wrong start, flow or status codes.

// File: rtl/sfx_pkg.sv
// Shared codes and state types for the serial frame transmitter.
// Assumes 32-bit link words; ordered set codes sit in bits 7..0, upper bits zero.
package sfx_pkg;

    localparam logic [7:0] OS_FILL     = 8'h01;
    localparam logic [7:0] OS_MARK     = 8'h02;
    localparam logic [7:0] OS_SOF_BASE = 8'h10;
    localparam logic [7:0] OS_GO       = 8'h20;
    localparam logic [7:0] OS_STOP     = 8'h21;
    localparam logic [7:0] OS_STAT_BASE = 8'h30;
    localparam logic [7:0] OS_END_DATA = 8'h40;
    localparam logic [7:0] OS_END_SYNC = 8'h41;

    typedef enum logic [2:0] {
        ST_GAP, ST_SOF, ST_DATA, ST_FLOW, ST_SEOF, ST_TEOF
    } fsm_t;

    typedef enum logic [2:0] {
        SL_FILL, SL_MARK, SL_SOF, SL_DATA, SL_CRC, SL_FLOW, SL_STAT, SL_END
    } slot_t;

endpackage

// File: rtl/sfx_crc32.sv
// Running CRC over the data words of one frame.
// Assumes: clr and upd are never high together; one word per update, MSB first.
module sfx_crc32 #(
    parameter int          WORD_W = 32,
    parameter logic [31:0] POLY   = 32'h04C11DB7,
    parameter logic [31:0] SEED   = 32'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [WORD_W-1:0] din,
    output logic [31:0]       crc
);

    // Fold one word into the remainder, one bit per step from the top.
    function automatic logic [31:0] fold(input logic [31:0] c, input logic [WORD_W-1:0] d);
        logic [31:0] r;
        r = c;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (r[31] ^ d[b]) r = {r[30:0], 1'b0} ^ POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    // Remainder register: reseeded at frame start, advanced per popped word.
    always_ff @(posedge clk) begin
        if (!rst_n)   crc <= SEED;
        else if (clr) crc <= SEED;
        else if (upd) crc <= fold(crc, din);
    end

endmodule

// File: rtl/sfx_frame_fsm.sv
// Frame sequencer: decides which slot goes out each cycle and when to pop.
// Assumes a first-word-fall-through FIFO that only this block drains, so a
// non-empty FIFO seen in the gap cycle is still non-empty at the first data slot.
module sfx_frame_fsm
    import sfx_pkg::*;
#(
    parameter int MAX_WORDS = 512
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fifo_empty,
    input  logic  sync_req,
    input  logic  crc_on,
    output slot_t slot,
    output logic  pop,
    output logic  crc_clr,
    output logic  frame_sync,
    output logic  sync_taken
);

    localparam int CW = $clog2(MAX_WORDS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_WORDS);

    fsm_t          state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sync_q, sync_d;
    logic          crcon_q, crcon_d;
    logic          at_limit, close;

    // Word limit: one word in a SYNC frame, MAX_WORDS otherwise.
    assign at_limit = sync_q ? (cnt_q != '0) : (cnt_q >= LIMIT);

    // Close rule: never before the first word; then on empty, limit or a new SYNC request.
    assign close = (cnt_q != '0) &&
                   (fifo_empty || at_limit || (!sync_q && sync_req));

    // Next-state and slot selection.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sync_d  = sync_q;
        crcon_d = crcon_q;
        slot    = SL_FILL;
        pop     = 1'b0;
        crc_clr = 1'b0;
        case (state_q)
            ST_GAP: begin
                if (!fifo_empty) begin
                    slot    = sync_req ? SL_MARK : SL_FILL;
                    sync_d  = sync_req;
                    state_d = ST_SOF;
                end
            end
            ST_SOF: begin
                slot    = SL_SOF;
                crc_clr = 1'b1;
                cnt_d   = '0;
                crcon_d = crc_on;
                state_d = ST_DATA;
            end
            ST_DATA: begin
                if (!close) begin
                    slot  = SL_DATA;
                    pop   = 1'b1;
                    cnt_d = cnt_q + 1'b1;
                end else if (crcon_q) begin
                    slot    = SL_CRC;
                    state_d = ST_FLOW;
                end else begin
                    slot    = SL_FLOW;
                    state_d = ST_SEOF;
                end
            end
            ST_FLOW: begin
                slot    = SL_FLOW;
                state_d = ST_SEOF;
            end
            ST_SEOF: begin
                slot    = SL_STAT;
                state_d = ST_TEOF;
            end
            ST_TEOF: begin
                slot    = SL_END;
                state_d = ST_GAP;
            end
            default: state_d = ST_GAP;
        endcase
    end

    // State, word count and per-frame mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GAP;
            cnt_q   <= '0;
            sync_q  <= 1'b0;
            crcon_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sync_q  <= sync_d;
            crcon_q <= crcon_d;
        end
    end

    assign frame_sync = sync_q;
    assign sync_taken = pop && sync_q;

endmodule

// File: rtl/sfx_word_mux.sv
// Output stage: builds the word for the chosen slot and registers it.
// Assumes WORD_W >= 8; ordered set codes are zero-extended.
module sfx_word_mux
    import sfx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             slot,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic [31:0]       crc,
    input  logic              frame_sync,
    input  logic              backoff,
    input  logic [2:0]        sof_flags,
    input  logic              overrun,
    input  logic              not_ready,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_is_os
);

    // Register the word and its ordered-set tag for the selected slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word  <= WORD_W'(OS_FILL);
            tx_is_os <= 1'b1;
        end else begin
            tx_is_os <= 1'b1;
            case (slot)
                SL_FILL: tx_word <= WORD_W'(OS_FILL);
                SL_MARK: tx_word <= WORD_W'(OS_MARK);
                SL_SOF:  tx_word <= WORD_W'({OS_SOF_BASE[7:3], sof_flags});
                SL_DATA: begin
                    tx_word  <= fifo_data;
                    tx_is_os <= 1'b0;
                end
                SL_CRC: begin
                    tx_word  <= WORD_W'(crc);
                    tx_is_os <= 1'b0;
                end
                SL_FLOW: tx_word <= WORD_W'(backoff ? OS_STOP : OS_GO);
                SL_STAT: tx_word <= WORD_W'({OS_STAT_BASE[7:2], overrun, not_ready});
                SL_END:  tx_word <= WORD_W'(frame_sync ? OS_END_SYNC : OS_END_DATA);
                default: tx_word <= WORD_W'(OS_FILL);
            endcase
        end
    end

endmodule

// File: rtl/sfx_frame_tx.sv
// Top: serial link frame transmitter fed by a fall-through word FIFO.
// Assumes the downstream encoder accepts one word every cycle.
module sfx_frame_tx #(
    parameter int MAX_WORDS = 512,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              sync_req,
    output logic              sync_taken,
    input  logic              crc_on,
    input  logic              backoff,
    input  logic [2:0]        sof_flags,
    input  logic              overrun,
    input  logic              not_ready,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_is_os
);

    sfx_pkg::slot_t slot;
    logic           crc_clr;
    logic           frame_sync;
    logic [31:0]    crc;

    sfx_frame_fsm #(.MAX_WORDS(MAX_WORDS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .sync_req   (sync_req),
        .crc_on     (crc_on),
        .slot       (slot),
        .pop        (fifo_pop),
        .crc_clr    (crc_clr),
        .frame_sync (frame_sync),
        .sync_taken (sync_taken)
    );

    sfx_crc32 #(.WORD_W(WORD_W)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .upd   (fifo_pop),
        .din   (fifo_data),
        .crc   (crc)
    );

    sfx_word_mux #(.WORD_W(WORD_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .fifo_data  (fifo_data),
        .crc        (crc),
        .frame_sync (frame_sync),
        .backoff    (backoff),
        .sof_flags  (sof_flags),
        .overrun    (overrun),
        .not_ready  (not_ready),
        .tx_word    (tx_word),
        .tx_is_os   (tx_is_os)
    );

endmodule

// File: rtl/sfx_frame_tx_chk.sv
// Protocol checker for sfx_frame_tx, bound to every instance of the top.
module sfx_frame_tx_chk #(
    parameter int MAX_WORDS = 512,
    parameter int WORD_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty,
    input logic              fifo_pop,
    input logic              sync_taken,
    input logic [WORD_W-1:0] tx_word,
    input logic              tx_is_os
);

    localparam int CW = $clog2(MAX_WORDS + 2);

    logic is_sof, is_flow, is_stat, is_end, is_gap;
    logic [CW-1:0] run_q;

    assign is_sof  = tx_is_os && (tx_word >> 3) == WORD_W'(2);
    assign is_flow = tx_is_os && (tx_word == WORD_W'(8'h20) || tx_word == WORD_W'(8'h21));
    assign is_stat = tx_is_os && (tx_word >> 2) == WORD_W'(12);
    assign is_end  = tx_is_os && (tx_word == WORD_W'(8'h40) || tx_word == WORD_W'(8'h41));
    assign is_gap  = tx_is_os && (tx_word == WORD_W'(8'h01) || tx_word == WORD_W'(8'h02));

    // Length of the current run of back-to-back pops.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (fifo_pop) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    assert_pop_nonempty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_sync_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_taken |-> fifo_pop);

    assert_sof_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_sof |-> $past(is_gap));

    assert_stat_after_flow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_stat |-> $past(is_flow));

    assert_end_after_stat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_end |-> $past(is_stat));

    assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(MAX_WORDS));

endmodule

bind sfx_frame_tx sfx_frame_tx_chk #(.MAX_WORDS(MAX_WORDS), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .sync_taken (sync_taken),
    .tx_word    (tx_word),
    .tx_is_os   (tx_is_os)
);

// File: tb/sfx_frame_tx_tb.sv
module sfx_frame_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_data = '0;
    logic        fifo_pop;
    logic        sync_req = 1'b0;
    logic        sync_taken;
    logic        crc_on = 1'b0;
    logic        backoff = 1'b0;
    logic [2:0]  sof_flags = '0;
    logic        overrun = 1'b0;
    logic        not_ready = 1'b0;
    logic [31:0] tx_word;
    logic        tx_is_os;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] src_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] fbuf[$];
    int          flen_q[$];
    bit          fsync_q[$];
    int          stage = 0;
    bit          cur_sync = 0;
    logic [31:0] prev_w = 32'h1;
    logic        prev_os = 1'b1;
    logic        pop_edge = 1'b0;
    logic        take_edge = 1'b0;

    always #5 clk = ~clk;

    sfx_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .sync_req(sync_req), .sync_taken(sync_taken),
        .crc_on(crc_on), .backoff(backoff), .sof_flags(sof_flags),
        .overrun(overrun), .not_ready(not_ready), .tx_word(tx_word), .tx_is_os(tx_is_os)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] words[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (words[k]) begin
            for (int b = 31; b >= 0; b--) begin
                logic top = c[31] ^ words[k][b];
                c = c << 1;
                if (top) c = c ^ 32'h04C11DB7;
            end
        end
        return c;
    endfunction

    task automatic drive_fifo();
        fifo_empty = (src_q.size() == 0);
        fifo_data  = (src_q.size() == 0) ? 32'h0 : src_q[0];
    endtask

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] v = $urandom;
            src_q.push_back(v);
            exp_q.push_back(v);
        end
        drive_fifo();
    endtask

    // Parse one output word against the frame rules.
    task automatic parse(input logic [31:0] w, input logic os);
        case (stage)
            0: begin
                if (os && (w >> 3) == 32'd2) begin
                    chk(prev_os && (prev_w == 32'h1 || prev_w == 32'h2), "R2 gap before start", prev_w, 32'h1);
                    chk(w == {29'd2, sof_flags}, "R4 start flags", w, {29'd2, sof_flags});
                    cur_sync = (prev_w == 32'h2);
                    fbuf.delete();
                    stage = 1;
                end else if (!(os && (w == 32'h1 || w == 32'h2))) begin
                    chk(0, "R2 fill between frames", w, 32'h1);
                end
            end
            1: begin
                if (!os) fbuf.push_back(w);
                else if (w == 32'h20 || w == 32'h21) begin
                    logic [31:0] got_crc = '0;
                    bit same = 1;
                    chk(w == (backoff ? 32'h21 : 32'h20), "R10 flow code", w, backoff ? 32'h21 : 32'h20);
                    if (crc_on) begin
                        if (fbuf.size() > 0) got_crc = fbuf.pop_back();
                        chk(got_crc == ref_crc(fbuf), "R9 crc word", got_crc, ref_crc(fbuf));
                    end
                    chk(fbuf.size() >= 1 && fbuf.size() <= 512, "R5 frame length", fbuf.size(), 512);
                    if (cur_sync) chk(fbuf.size() == 1, "R7 sync frame one word", fbuf.size(), 1);
                    foreach (fbuf[k]) begin
                        logic [31:0] e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD;
                        if (fbuf[k] !== e && same) begin
                            same = 0;
                            chk(0, "R12 data order", fbuf[k], e);
                        end
                    end
                    if (same) chk(1, "R12 data order", 0, 0);
                    stage = 2;
                end else begin
                    chk(0, "R3 frame order", w, 32'h20);
                    stage = 0;
                end
            end
            2: begin
                chk(os && w == {30'd12, overrun, not_ready}, "R11 status code", w, {30'd12, overrun, not_ready});
                stage = 3;
            end
            default: begin
                chk(os && w == (cur_sync ? 32'h41 : 32'h40), "R7 frame end code", w, cur_sync ? 32'h41 : 32'h40);
                flen_q.push_back(fbuf.size());
                fsync_q.push_back(cur_sync);
                stage = 0;
            end
        endcase
        prev_w = w;
        prev_os = os;
    endtask

    always @(posedge clk) begin
        pop_edge  <= fifo_pop;
        take_edge <= sync_taken;
    end

    // Monitor: retire popped words, parse the registered output, release SYNC.
    always @(negedge clk) begin
        if (rst_n) begin
            if (pop_edge && src_q.size() > 0) void'(src_q.pop_front());
            drive_fifo();
            if (take_edge) sync_req = 1'b0;
            parse(tx_word, tx_is_os);
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (src_q.size() != 0 || stage != 0);
        repeat (4) @(negedge clk);
    endtask

    function automatic int sum_len();
        int s = 0;
        foreach (flen_q[k]) s += flen_q[k];
        return s;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, words waiting must not be popped.
        @(negedge clk);
        push_words(3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(tx_word == 32'h1 && tx_is_os && !fifo_pop, "R1 reset output", {tx_word[30:0], fifo_pop}, 32'h2);
        end
        rst_n = 1'b1;
        wait_idle();
        chk(flen_q.size() == 1 && flen_q[0] == 3, "R6 post-reset frame", flen_q.size() > 0 ? flen_q[0] : -1, 3);

        // R5: long burst splits at the word limit.
        flen_q.delete(); fsync_q.delete();
        crc_on = 1'b1;
        push_words(600);
        wait_idle();
        chk(flen_q.size() == 2 && flen_q[0] == 512 && flen_q[1] == 88, "R5 split 512+88",
            flen_q.size() > 0 ? flen_q[0] : -1, 512);

        // R7: SYNC requested with the burst.
        flen_q.delete(); fsync_q.delete();
        sync_req = 1'b1;
        push_words(5);
        wait_idle();
        chk(flen_q.size() == 2 && fsync_q[0] && flen_q[0] == 1 && !fsync_q[1] && flen_q[1] == 4,
            "R7 sync then normal", flen_q.size(), 2);

        // R8: SYNC raised mid-frame closes it early.
        flen_q.delete(); fsync_q.delete();
        crc_on = 1'b0;
        push_words(30);
        do @(negedge clk); while (!(stage == 1 && fbuf.size() >= 5));
        sync_req = 1'b1;
        wait_idle();
        chk(flen_q.size() == 3 && flen_q[0] >= 5 && flen_q[0] < 29 && fsync_q[1] && flen_q[1] == 1
            && sum_len() == 30, "R8 early close", flen_q.size() > 0 ? flen_q[0] : -1, 5);

        // R8: SYNC raised in the start cycle still leaves one word.
        flen_q.delete(); fsync_q.delete();
        push_words(3);
        @(negedge clk);
        sync_req = 1'b1;
        wait_idle();
        chk(flen_q.size() == 3 && flen_q[0] == 1 && flen_q[1] == 1 && flen_q[2] == 1
            && !fsync_q[0] && fsync_q[1] && !fsync_q[2], "R8 minimum one word",
            flen_q.size(), 3);

        // Random bursts with random flags, CRC, flow and status bits.
        for (int t = 0; t < 60; t++) begin
            int n = 1 + ($urandom % 40);
            bit sy = ($urandom % 8) == 0;
            flen_q.delete(); fsync_q.delete();
            sof_flags = 3'($urandom);
            crc_on    = 1'($urandom);
            backoff   = 1'($urandom);
            overrun   = 1'($urandom);
            not_ready = 1'($urandom);
            if (sy) sync_req = 1'b1;
            push_words(n);
            wait_idle();
            if (sy) chk(flen_q.size() >= 1 && fsync_q[0] && sum_len() == n, "R7 random sync", sum_len(), n);
            else    chk(flen_q.size() == 1 && sum_len() == n, "R6 burst one frame", sum_len(), n);
        end
        chk(exp_q.size() == 0, "R12 all words sent", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog: got %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule